// File: doc/BRIEF.md
# Spike-Driven Integrate-and-Fire Convolution Cell

This block is one cell of a two-dimensional grid that convolves a stream of address events with a 3x3 kernel. Each cell holds a signed accumulator. When the address decoder selects the cell, the cell adds the centre weight of the kernel. In the same cycle it echoes the hit on a single wire to its eight surrounding cells. When a surrounding cell echoes its own hit, this cell adds the kernel weight that belongs to that cell's relative position. A hit therefore spreads a complete copy of the kernel over the nine cells of its neighbourhood in one clock.

When the updated accumulator reaches the grid-wide threshold, the cell fires. The accumulator returns to zero, and a single pending request is latched for the output arbiter. The request stays up until the arbiter clears it. Kernel weights may be negative, so the accumulator clamps at both ends of its signed range and never wraps.

Top module: `sconv_cell`

## Requirements
- R1: While reset is asserted and after it is released, fire_req_o is 0 and the accumulator holds 0.
- R2: nbr_req_o equals hit_i in the same cycle, with no register in between.
- R3: A hit on the cell adds the centre weight, which is kernel position 4, to the accumulator.
- R4: Bit k of nbr_spk_i adds the weight at kernel position 0, 1, 2, 3, 5, 6, 7 or 8 for k = 0 to 7. Positions are row-major: position = 3*row + col, with row 0 at the top and column 0 at the left. Bit 7 is therefore the bottom-right neighbour. The weight at position p occupies coef_i[p*W +: W] in two's complement.
- R5: When the hit and any number of neighbour lines are active in the same cycle, all of their weights are added to the accumulator before any clamping.
- R6: The updated value is clamped to the range -2^(W-1) .. 2^(W-1)-1 (that is, -128 .. +127 for W = 8) and never wraps.
- R7: In a cycle with at least one active event, the cell fires if the clamped value is greater than or equal to thresh_i, compared as signed numbers. When it fires, the accumulator becomes 0 and fire_req_o is 1 from the next cycle. When it does not fire, the accumulator takes the clamped value.
- R8: fire_req_o stays at 1 until a cycle with fire_clr_i high and no new firing, and it is 0 after that cycle. If the cell fires in the same cycle as the clear, fire_req_o stays at 1.
- R9: In a cycle with no hit and no neighbour line active, the accumulator is unchanged and the cell does not fire, even when the threshold is at or below the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_i | input | 9*W | Kernel weights, position p at bits [p*W +: W] |
| thresh_i | input | W | Signed firing threshold shared by the grid |
| hit_i | input | 1 | This cell is addressed by the current input event |
| nbr_spk_i | input | 8 | Echoed hits from the eight surrounding cells |
| fire_clr_i | input | 1 | Arbiter clears the pending fire request |
| nbr_req_o | output | 1 | Hit echo sent to the eight surrounding cells |
| fire_req_o | output | 1 | Pending fire request to the arbiter |

## Verification
The bench builds the cell with W = 5, so every weight value from -16 to +15 can be driven at every one of the nine kernel positions. It also sweeps all 511 non-empty combinations of hit and neighbour lines, with both a positive-leaning and a negative-leaning kernel. The narrow width makes sums overrun the range in both directions easily, so clamping is exercised often. The hidden accumulator is read through the ports: the bench applies a zero-weight hit with the threshold set to one above, and then equal to, the value predicted by its own arithmetic model.

// File: rtl/sconv_pkg.sv
package sconv_pkg;
  localparam int KPOS   = 9;
  localparam int NNBR   = 8;
  localparam int CENTRE = 4;

  // neighbour line index -> row-major kernel position (centre skipped)
  function automatic int nbr_pos(input int k);
    return (k < CENTRE) ? k : k + 1;
  endfunction
endpackage

// File: rtl/sconv_kernel_sel.sv
module sconv_kernel_sel #(
  parameter int W = 8
) (
  input  logic [sconv_pkg::KPOS*W-1:0]     coef_flat,
  input  logic                             hit,
  input  logic [sconv_pkg::NNBR-1:0]       nbr_spk,
  output logic signed [W+4:0]              delta,
  output logic                             any_evt
);
  localparam int SW = W + 5;

  logic signed [SW-1:0] term [sconv_pkg::KPOS];

  genvar g;
  for (g = 0; g < sconv_pkg::NNBR; g++) begin : g_nbr
    localparam int P = sconv_pkg::nbr_pos(g);
    assign term[P] = nbr_spk[g] ? SW'($signed(coef_flat[P*W +: W])) : '0;
  end

  assign term[sconv_pkg::CENTRE] =
    hit ? SW'($signed(coef_flat[sconv_pkg::CENTRE*W +: W])) : '0;

  always_comb begin
    delta = '0;
    for (int i = 0; i < sconv_pkg::KPOS; i++) delta = delta + term[i];
  end

  assign any_evt = hit | (|nbr_spk);
endmodule

// File: rtl/sconv_sat_acc.sv
module sconv_sat_acc #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W+4:0] delta,
  input  logic                any_evt,
  input  logic signed [W-1:0] thresh,
  output logic signed [W-1:0] state,
  output logic                fire_evt
);
  localparam int SW   = W + 5;
  localparam int HI_I = 2**(W-1) - 1;
  localparam logic signed [SW-1:0] HI = SW'(HI_I);
  localparam logic signed [SW-1:0] LO = SW'(-HI_I - 1);

  function automatic logic signed [W-1:0] clip(input logic signed [SW-1:0] v);
    if (v > HI) return W'(HI);
    if (v < LO) return W'(LO);
    return W'(v);
  endfunction

  logic signed [SW-1:0] raw_sum;
  logic signed [W-1:0]  upd;

  assign raw_sum  = SW'(state) + delta;
  assign upd      = clip(raw_sum);
  assign fire_evt = any_evt && (upd >= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= '0;
    else if (any_evt) state <= fire_evt ? '0 : upd;
  end
endmodule

// File: rtl/sconv_fire_latch.sv
module sconv_fire_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_evt,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (fire_evt) pend <= 1'b1;
    else if (clr)      pend <= 1'b0;
  end
endmodule

// File: rtl/sconv_cell.sv
module sconv_cell #(
  parameter int W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [sconv_pkg::KPOS*W-1:0]  coef_i,
  input  logic [W-1:0]                  thresh_i,
  input  logic                          hit_i,
  input  logic [sconv_pkg::NNBR-1:0]    nbr_spk_i,
  input  logic                          fire_clr_i,
  output logic                          nbr_req_o,
  output logic                          fire_req_o
);
  logic signed [W+4:0] delta;
  logic                any_evt;
  logic                fire_evt;
  logic signed [W-1:0] acc_state;

  assign nbr_req_o = hit_i;

  sconv_kernel_sel #(.W(W)) i_sel (
    .coef_flat (coef_i),
    .hit       (hit_i),
    .nbr_spk   (nbr_spk_i),
    .delta     (delta),
    .any_evt   (any_evt)
  );

  sconv_sat_acc #(.W(W)) i_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .delta    (delta),
    .any_evt  (any_evt),
    .thresh   ($signed(thresh_i)),
    .state    (acc_state),
    .fire_evt (fire_evt)
  );

  sconv_fire_latch i_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_evt (fire_evt),
    .clr      (fire_clr_i),
    .pend     (fire_req_o)
  );
endmodule

// File: rtl/sconv_cell_chk.sv
module sconv_cell_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         any_evt,
  input logic         fire_evt,
  input logic         fire_clr_i,
  input logic         fire_req_o,
  input logic [W-1:0] acc_state,
  input logic [W-1:0] thresh_i
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(acc_state)); // R9

  AST_FIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> acc_state == '0); // R7

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> fire_req_o); // R7

  AST_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (any_evt && !fire_evt) |=> $signed(acc_state) < $signed($past(thresh_i))); // R7

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_req_o && !fire_clr_i) |=> fire_req_o); // R8

  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_req_o && fire_clr_i && !fire_evt) |=> !fire_req_o); // R8
endmodule

bind sconv_cell sconv_cell_chk #(.W(W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .any_evt    (any_evt),
  .fire_evt   (fire_evt),
  .fire_clr_i (fire_clr_i),
  .fire_req_o (fire_req_o),
  .acc_state  (acc_state),
  .thresh_i   (thresh_i)
);

// File: tb/test_sconv_cell.sv
module test_sconv_cell;
  localparam int W    = 5;
  localparam int MAXV = 15;
  localparam int MINV = -16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [9*W-1:0] coef_bus;
  logic [W-1:0]   thresh_bus;
  logic           hit = 1'b0;
  logic [7:0]     nbr = '0;
  logic           clr_r = 1'b0;
  logic           zero_k = 1'b0;
  logic           nbr_req_o;
  logic           fire_req_o;

  int kern [9];
  int thr = MAXV;
  int ms = 0;           // model accumulator
  logic mp = 1'b0;      // model pending flag
  int checks = 0;
  int errs = 0;
  const int pos_of [8] = '{0, 1, 2, 3, 5, 6, 7, 8};

  always #10 clk = ~clk;

  always_comb begin
    for (int p = 0; p < 9; p++)
      coef_bus[p*W +: W] = zero_k ? '0 : W'(kern[p]);
    thresh_bus = W'(thr);
  end

  sconv_cell #(.W(W)) i_sconv_cell (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_i     (coef_bus),
    .thresh_i   (thresh_bus),
    .hit_i      (hit),
    .nbr_spk_i  (nbr),
    .fire_clr_i (clr_r),
    .nbr_req_o  (nbr_req_o),
    .fire_req_o (fire_req_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clamp(input int v);
    if (v > MAXV) return MAXV;
    else if (v < MINV) return MINV;
    else return v;
  endfunction

  task automatic step(input logic h, input logic [7:0] m, input logic c,
                      input logic zk, input string tag);
    int sum;
    logic ev, fire;
    @(negedge clk);
    hit = h; nbr = m; clr_r = c; zero_k = zk;
    #1;
    check(nbr_req_o === h, "R2", int'(nbr_req_o), int'(h));
    ev = h || (m != 0);
    sum = ms;
    if (!zk) begin
      if (h) sum += kern[4];
      for (int k = 0; k < 8; k++) if (m[k]) sum += kern[pos_of[k]];
    end
    sum = clamp(sum);
    fire = ev && (sum >= thr);
    if (ev) ms = fire ? 0 : sum;
    if (fire) mp = 1'b1;
    else if (c) mp = 1'b0;
    @(posedge clk);
    #1;
    check(fire_req_o === mp, tag, int'(fire_req_o), int'(mp));
    @(negedge clk);
    hit = 1'b0; nbr = '0; clr_r = 1'b0; zero_k = 1'b0;
  endtask

  // read the accumulator through the ports: zero-weight hit at ms+1 then ms
  task automatic probe(input string tag);
    int keep;
    keep = thr;
    if (ms < MAXV) begin
      thr = ms + 1;
      step(1'b1, '0, 1'b1, 1'b1, tag);
    end
    thr = ms;
    step(1'b1, '0, 1'b1, 1'b1, tag);
    thr = keep;
  endtask

  task automatic apply_mask(input int mask, input string tag);
    logic [7:0] m;
    for (int k = 0; k < 8; k++) m[k] = mask[pos_of[k]];
    step(mask[4], m, 1'b1, 1'b0, tag);
  endtask

  initial begin
    for (int p = 0; p < 9; p++) kern[p] = 0;
    repeat (3) @(posedge clk);
    #1;
    check(fire_req_o === 1'b0, "R1", int'(fire_req_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(fire_req_o === 1'b0, "R1", int'(fire_req_o), 0);
    probe("R1");

    // R3 / R4: every weight value at every position, applied twice
    for (int p = 0; p < 9; p++) begin
      for (int c = MINV; c <= MAXV; c++) begin
        for (int q = 0; q < 9; q++) kern[q] = 0;
        kern[p] = c;
        thr = MAXV;
        apply_mask(1 << p, (p == 4) ? "R3" : "R4");
        apply_mask(1 << p, (p == 4) ? "R3" : "R4");
        probe((p == 4) ? "R3" : "R4");
      end
    end

    // R5 / R6: all event combinations, positive-leaning kernel
    kern = '{7, -3, 5, -8, 2, 6, -1, 4, 15};
    thr = MAXV;
    for (int m = 1; m < 512; m++) begin
      apply_mask(m, "R5");
      probe("R6");
    end

    // R5 / R6: all event combinations, negative-leaning kernel
    kern = '{-9, 3, -16, -7, -12, 2, -5, -14, 1};
    for (int m = 1; m < 512; m++) begin
      apply_mask(m, "R5");
      probe("R6");
    end

    // R7: threshold boundary, equal fires, one above does not
    kern = '{0, 0, 0, 0, 6, 0, 0, 0, 0};
    for (int t = MINV; t <= MAXV; t++) begin
      thr = t;
      step(1'b1, '0, 1'b1, 1'b0, "R7");
      probe("R7");
    end

    // R8: hold without clear, clear drops, fire during clear keeps it
    thr = MINV;
    step(1'b1, '0, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, 1'b0, "R8");
    step(1'b0, '0, 1'b1, 1'b0, "R8");
    step(1'b1, '0, 1'b0, 1'b1, "R8");
    step(1'b1, '0, 1'b1, 1'b1, "R8");
    step(1'b0, '0, 1'b1, 1'b0, "R8");

    // R9: idle cycles with threshold below the accumulator
    kern = '{0, 0, 0, 0, -5, 0, 0, 0, 0};
    thr = MAXV;
    step(1'b1, '0, 1'b1, 1'b0, "R9");
    thr = MINV;
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, 1'b0, "R9");
    thr = MAXV;
    probe("R9");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule